// File: doc/BRIEF.md
# Power mode control register unit

This block holds the two power-management registers of a small microcontroller and sits on its special-function register bus. Software sets the target low-power mode in the sleep-control register, then writes a one to bit 0 of the power-mode trigger register. The block answers with a single-cycle request that carries the selected mode to the sleep sequencer outside.

The sleep-control register also reports whether each oscillator is stable and records the cause of the most recent reset. It holds the oscillator power-down control, which has two automatic behaviours. A request to set it while an oscillator calibration is running is held back until the calibration ends. Any change of the clock-select bit in the clock-control register clears it.

The block is read combinationally. It takes a write when the write strobe is high at a rising clock edge.

Top module: `pwr_mode_regs`

## Requirements
- R1: Reading the trigger register (address 0x87) always returns 0x00, even in the cycle it is written. Any address other than 0x87 and 0xBE also reads 0x00.
- R2: A write to address 0x87 with bit 0 set makes `pm_req` high for exactly the next cycle. Every other cycle it is low.
- R3: Sleep-control (address 0xBE) bits 1:0 are a read/write mode field that resets to 00. `pm_mode` always shows this field, so while `pm_req` is high it carries the mode held at that time.
- R4: In the sleep-control register, bit 7 reads 0, bit 6 shows `xosc_stable` and bit 5 shows `hfrc_stable`. Software writes to bits 7:3 have no effect.
- R5: Bits 4:3 of the sleep-control register give the cause of the last reset. The codes are 00 for power-on (`rst_n` low, which overrides everything), 01 for an `ext_rst_evt` pulse and 10 for a `wdt_rst_evt` pulse. If both pulses arrive in the same cycle, the code is 10. A new event replaces the old code.
- R6: Bit 2 of the sleep-control register (`osc_pd`) resets to 1. When no calibration is running, a write stores the new value from the next cycle on.
- R7: A write of 1 to bit 2 while `cal_busy` is high leaves the bit unchanged. The bit becomes 1 after the first edge at which `cal_busy` is low. A write of 0 during a calibration takes effect at once and cancels a held set.
- R8: A change of `clk_sel` between consecutive edges clears bit 2 at that edge and throws away any held set. This clear wins over a write of 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational from `sfr_addr` |
| xosc_stable | input | 1 | Crystal oscillator powered and stable |
| hfrc_stable | input | 1 | High-frequency RC oscillator powered and stable |
| ext_rst_evt | input | 1 | One-cycle pulse: external pin reset happened |
| wdt_rst_evt | input | 1 | One-cycle pulse: watchdog reset happened |
| clk_sel | input | 1 | Oscillator select bit of the clock-control register |
| cal_busy | input | 1 | Oscillator calibration in progress |
| pm_req | output | 1 | One-cycle request to enter a power mode |
| pm_mode | output | 2 | Power mode that goes with the request |
| osc_pd | output | 1 | Power down the oscillator that is not selected |

## Verification
Three things can update the power-down bit in the same edge: a software write, the release of a held set when the calibration ends, and the clear caused by a change of `clk_sel`. Directed steps force these collisions. One step flips `clk_sel` in the same cycle as a write of 1. Another sets a held value under calibration, then flips the select before the calibration drops. The random phase flips `clk_sel` and `cal_busy` often enough that they keep landing on writes. A reference model built from R6 to R8 judges every cycle, and it gives the clear the highest priority.

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs #(
  parameter logic [7:0] TRIG_ADDR  = 8'h87,
  parameter logic [7:0] SLEEP_ADDR = 8'hBE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_we,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       xosc_stable,
  input  logic       hfrc_stable,
  input  logic       ext_rst_evt,
  input  logic       wdt_rst_evt,
  input  logic       clk_sel,
  input  logic       cal_busy,
  output logic       pm_req,
  output logic [1:0] pm_mode,
  output logic       osc_pd
);

  logic [1:0] mode_q;
  logic [1:0] cause_q;
  logic       pd_q;
  logic       pend_q;
  logic       req_q;
  logic       sel_q;

  wire wr_trig  = sfr_we && (sfr_addr == TRIG_ADDR);
  wire wr_sleep = sfr_we && (sfr_addr == SLEEP_ADDR);
  wire sel_flip = clk_sel ^ sel_q;

  always_ff @(posedge clk) sel_q <= clk_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'b00;
      cause_q <= 2'b00;
      pd_q    <= 1'b1;
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= wr_trig && sfr_wdata[0];
      if (wr_sleep) mode_q <= sfr_wdata[1:0];
      if (wdt_rst_evt)      cause_q <= 2'b10;
      else if (ext_rst_evt) cause_q <= 2'b01;
      if (sel_flip) begin
        pd_q   <= 1'b0;
        pend_q <= 1'b0;
      end else if (wr_sleep) begin
        if (sfr_wdata[2] && cal_busy) begin
          pend_q <= 1'b1;
        end else begin
          pd_q   <= sfr_wdata[2];
          pend_q <= 1'b0;
        end
      end else if (pend_q && !cal_busy) begin
        pd_q   <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    sfr_rdata = 8'h00;
    if (sfr_addr == SLEEP_ADDR)
      sfr_rdata = {1'b0, xosc_stable, hfrc_stable, cause_q, pd_q, mode_q};
  end

  assign pm_req  = req_q;
  assign pm_mode = mode_q;
  assign osc_pd  = pd_q;

endmodule

// File: rtl/pwr_mode_regs_chk.sv
module pwr_mode_regs_chk #(
  parameter logic [7:0] TRIG_ADDR  = 8'h87,
  parameter logic [7:0] SLEEP_ADDR = 8'hBE
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sfr_addr,
  input logic       sfr_we,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata,
  input logic       xosc_stable,
  input logic       hfrc_stable,
  input logic       ext_rst_evt,
  input logic       wdt_rst_evt,
  input logic       clk_sel,
  input logic       cal_busy,
  input logic       pm_req,
  input logic [1:0] pm_mode,
  input logic       osc_pd,
  input logic [1:0] cause
);

  p_trig_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == TRIG_ADDR) |-> (sfr_rdata == 8'h00));

  p_req_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == TRIG_ADDR && sfr_wdata[0]) |=> pm_req);

  p_req_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_we && sfr_addr == TRIG_ADDR && sfr_wdata[0]) |=> !pm_req);

  p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == SLEEP_ADDR) |=> (pm_mode == $past(sfr_wdata[1:0])));

  p_status_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == SLEEP_ADDR) |-> (sfr_rdata[7:5] == {1'b0, xosc_stable, hfrc_stable}));

  p_cause_wdt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_evt |=> (cause == 2'b10));

  p_cause_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rst_evt && !wdt_rst_evt) |=> (cause == 2'b01));

  p_defer_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == SLEEP_ADDR && sfr_wdata[2] && cal_busy && !osc_pd
     && clk_sel == $past(clk_sel)) |=> !osc_pd);

  p_flip_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != $past(clk_sel)) |=> !osc_pd);

endmodule

bind pwr_mode_regs pwr_mode_regs_chk #(
  .TRIG_ADDR(TRIG_ADDR), .SLEEP_ADDR(SLEEP_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .xosc_stable(xosc_stable),
  .hfrc_stable(hfrc_stable), .ext_rst_evt(ext_rst_evt), .wdt_rst_evt(wdt_rst_evt),
  .clk_sel(clk_sel), .cal_busy(cal_busy), .pm_req(pm_req), .pm_mode(pm_mode),
  .osc_pd(osc_pd), .cause(cause_q)
);

// File: tb/pwr_mode_regs_tb.sv
module pwr_mode_regs_tb;
  localparam logic [7:0] TA = 8'h87;
  localparam logic [7:0] SA = 8'hBE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic xo = 1'b0, hf = 1'b0, ext = 1'b0, wdt = 1'b0, sel = 1'b0, cal = 1'b0;
  logic pm_req, osc_pd;
  logic [1:0] pm_mode;

  logic [1:0] m_mode, m_cause;
  logic m_pd, m_pend, m_req, m_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_regs u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .xosc_stable(xo),
    .hfrc_stable(hf), .ext_rst_evt(ext), .wdt_rst_evt(wdt), .clk_sel(sel),
    .cal_busy(cal), .pm_req(pm_req), .pm_mode(pm_mode), .osc_pd(osc_pd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == SA) return {1'b0, xo, hf, m_cause, m_pd, m_mode};
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_mode = 2'b00; m_cause = 2'b00; m_pd = 1'b1; m_pend = 1'b0; m_req = 1'b0; m_sel = 1'b0;
  endtask

  task automatic step(input logic [7:0] a, input logic we, input logic [7:0] wd);
    string tag;
    logic flip, wr_s;
    sfr_addr = a; sfr_we = we; sfr_wdata = wd;
    #1;
    chk(sfr_rdata == exp_rd(a), (a == SA) ? "R4" : "R1", sfr_rdata, exp_rd(a));
    flip = sel ^ m_sel;
    wr_s = we && a == SA;
    tag = flip ? "R8" : ((cal || m_pend) ? "R7" : "R6");
    m_req = we && a == TA && wd[0];
    if (wr_s) m_mode = wd[1:0];
    if (wdt) m_cause = 2'b10;
    else if (ext) m_cause = 2'b01;
    if (flip) begin m_pd = 1'b0; m_pend = 1'b0; end
    else if (wr_s) begin
      if (wd[2] && cal) m_pend = 1'b1;
      else begin m_pd = wd[2]; m_pend = 1'b0; end
    end else if (m_pend && !cal) begin m_pd = 1'b1; m_pend = 1'b0; end
    m_sel = sel;
    @(posedge clk); @(negedge clk);
    chk(pm_req == m_req, "R2", pm_req, m_req);
    chk(pm_mode == m_mode, "R3", pm_mode, m_mode);
    chk(osc_pd == m_pd, tag, osc_pd, m_pd);
    ext = 1'b0; wdt = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sfr_we = 1'b0; sel = 1'b0; cal = 1'b0; ext = 1'b0; wdt = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sfr_addr = SA; #1;
    chk(sfr_rdata[4:0] == 5'b00100, "R5", sfr_rdata[4:0], 5'b00100);
    chk(osc_pd == 1'b1, "R6", osc_pd, 1);
    chk(pm_req == 1'b0 && pm_mode == 2'b00, "R2", {pm_req, pm_mode}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();
    // R3 R6: mode 2, power-down off, then trigger
    step(SA, 1'b1, 8'h02);
    chk(osc_pd == 1'b0, "R6", osc_pd, 0);
    step(TA, 1'b1, 8'hFF);
    chk(pm_req == 1'b1 && pm_mode == 2'd2, "R2", {pm_req, pm_mode}, 3'b110);
    step(TA, 1'b0, 8'h00);
    chk(pm_req == 1'b0, "R2", pm_req, 0);
    // R4: read-only bits ignore writes
    xo = 1'b1; hf = 1'b0;
    step(SA, 1'b1, 8'hF9);
    sfr_addr = SA; sfr_we = 1'b0; #1;
    chk(sfr_rdata == 8'h41, "R4", sfr_rdata, 8'h41);
    // R7: set deferred across calibration
    step(SA, 1'b1, 8'h00);
    cal = 1'b1;
    step(SA, 1'b1, 8'h04);
    chk(osc_pd == 1'b0, "R7", osc_pd, 0);
    repeat (3) step(8'h00, 1'b0, 8'h00);
    chk(osc_pd == 1'b0, "R7", osc_pd, 0);
    cal = 1'b0;
    step(8'h00, 1'b0, 8'h00);
    chk(osc_pd == 1'b1, "R7", osc_pd, 1);
    // R7: write 0 during calibration immediate, cancels held set
    cal = 1'b1;
    step(SA, 1'b1, 8'h00);
    step(SA, 1'b1, 8'h04);
    step(SA, 1'b1, 8'h00);
    cal = 1'b0;
    step(8'h00, 1'b0, 8'h00);
    chk(osc_pd == 1'b0, "R7", osc_pd, 0);
    // R8: flip discards held set
    cal = 1'b1;
    step(SA, 1'b1, 8'h04);
    sel = 1'b1;
    step(8'h00, 1'b0, 8'h00);
    cal = 1'b0;
    step(8'h00, 1'b0, 8'h00);
    chk(osc_pd == 1'b0, "R8", osc_pd, 0);
    // R8: flip beats same-cycle write of 1
    sel = 1'b0;
    step(SA, 1'b1, 8'h04);
    chk(osc_pd == 1'b0, "R8", osc_pd, 0);
    step(SA, 1'b1, 8'h04);
    chk(osc_pd == 1'b1, "R6", osc_pd, 1);
    sel = 1'b1;
    step(8'h00, 1'b0, 8'h00);
    chk(osc_pd == 1'b0, "R8", osc_pd, 0);
    // R5: reset cause sequence
    ext = 1'b1; step(8'h00, 1'b0, 8'h00);
    sfr_addr = SA; #1; chk(sfr_rdata[4:3] == 2'b01, "R5", sfr_rdata[4:3], 1);
    wdt = 1'b1; step(8'h00, 1'b0, 8'h00);
    sfr_addr = SA; #1; chk(sfr_rdata[4:3] == 2'b10, "R5", sfr_rdata[4:3], 2);
    ext = 1'b1; step(8'h00, 1'b0, 8'h00);
    sfr_addr = SA; #1; chk(sfr_rdata[4:3] == 2'b01, "R5", sfr_rdata[4:3], 1);
    ext = 1'b1; wdt = 1'b1; step(8'h00, 1'b0, 8'h00);
    sfr_addr = SA; #1; chk(sfr_rdata[4:3] == 2'b10, "R5", sfr_rdata[4:3], 2);
    do_reset();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = TA;
        1, 2: a = SA;
        default: a = 8'($urandom);
      endcase
      if ($urandom_range(0, 7) == 0) sel = ~sel;
      if ($urandom_range(0, 5) == 0) cal = ~cal;
      ext = ($urandom_range(0, 15) == 0);
      wdt = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 31) == 0) xo = ~xo;
      if ($urandom_range(0, 31) == 0) hf = ~hf;
      step(a, 1'($urandom_range(0, 1)), 8'($urandom));
    end
    finish_run();
  end
endmodule